// File: doc/BRIEF.md
# Digital Phase-Frequency Detector with Lock Qualification

This block compares a reference pulse train with the divided-down oscillator feedback pulse train and drives two pump-control outputs for an external charge pump. A rising edge on the reference raises `up`. A rising edge on the feedback raises `dn`. As soon as both are high, both are cleared together. Each pulse therefore lasts as long as the phase gap between the two edges, and its amplitude never changes. When the two inputs differ in frequency, the faster input keeps re-arming its own output first. The output pattern is then dominated by one side, which gives the detector an unbounded pull-in range.

The design runs on a fast sampling clock. Both edge inputs pass through `SYNC_STAGES` sampling flops and a rising-edge detector. A four-state machine, one instance for the whole detector, stands in for the two set-to-one flops and their shared clear:

- `PFD_IDLE`: both outputs low.
- `PFD_UP`: only `up` high.
- `PFD_DN`: only `dn` high.
- `PFD_BOTH`: both high for exactly one cycle. This is the short clear path that prevents a dead zone.

The transitions are:

- IDLE→UP on a reference edge alone.
- IDLE→DN on a feedback edge alone.
- IDLE→BOTH on both edges in the same cycle.
- UP→BOTH on a feedback edge.
- DN→BOTH on a reference edge.
- BOTH→UP, BOTH→DN or BOTH→IDLE, depending on which edges arrive during the clear cycle.
- A repeat edge on the side that is already set keeps the state unchanged.

A lock qualifier watches the pulses. It raises `lock` after 8 consecutive comparisons in which no pulse was wider than `lock_limit` clock cycles, and it drops `lock` as soon as any pulse grows wider than that.

Top module: `pfd_detector`

## Requirements
- R1: A synchronous `rst` drives `up`, `dn` and `lock` low in the following cycle. It also restarts the count of qualifying comparisons.
- R2: A reference rising edge raises `up`, which stays high until the both-high cycle. Further reference edges while `up` is already set are ignored and do not change its width.
- R3: A feedback rising edge raises `dn`, which stays high until the both-high cycle. Further feedback edges while `dn` is already set are ignored.
- R4: Whenever `up` and `dn` are both high, the next cycle never has both high. The clear lasts exactly one cycle.
- R5: If the reference edge leads the feedback edge by d clock cycles, `up` is high for d+1 cycles and `dn` for 1 cycle. If the feedback leads by d, `dn` is high for d+1 cycles and `up` for 1.
- R6: Edges that arrive in the same cycle give a minimum pulse: both `up` and `dn` high for exactly one cycle.
- R7: A reference faster than the feedback yields more `up` cycles than `dn` cycles over a window. A slower reference yields more `dn` cycles.
- R8: `lock` rises in the cycle after the both-high cycle that completes the 8th consecutive comparison whose pulse width (cycles high, counting the both-high cycle) is at most `lock_limit`.
- R9: `lock` falls one cycle after any pulse exceeds `lock_limit` cycles, while that pulse is still high. The qualifying count then restarts from zero, so 7 further good comparisons do not relock and the 8th does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference pulse train |
| fb_in | input | 1 | Divided oscillator feedback pulse train |
| lock_limit | input | LIMIT_W | Widest pulse, in clock cycles, that still counts toward lock; held static |
| up | output | 1 | Pump-up request |
| dn | output | 1 | Pump-down request |
| lock | output | 1 | Lock qualified |

## Verification
The assertions assume that each input stays high and stays low for at least one sampled clock cycle. Under that assumption a rising edge cannot be detected on two consecutive cycles, and the one-cycle clear cannot repeat back to back. They also assume `lock_limit` does not change while pulses are in flight. The stimulus drives both inputs on the falling clock edge, holds every high and low level for several cycles, and changes `lock_limit` only while the detector is idle or in reset.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Detector states: which pump outputs are currently set.
    typedef enum logic [1:0] {
        PFD_IDLE = 2'd0,
        PFD_UP   = 2'd1,
        PFD_DN   = 2'd2,
        PFD_BOTH = 2'd3
    } pfd_state_t;

    // Saturating increment for an arbitrary counter width.
    function automatic int unsigned sat_inc(input int unsigned val, input int unsigned max);
        return (val >= max) ? max : val + 1;
    endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] smp;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp  <= '0;
            last <= 1'b0;
        end else begin
            smp[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                smp[i] <= smp[i-1];
            end
            last <= smp[STAGES-1];
        end
    end

    assign rise = smp[STAGES-1] & ~last;
endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic up,
    output logic dn
);
    pfd_state_t state, state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= PFD_IDLE;
        else     state <= state_nx;
    end

    // Transitions: each edge sets its own side; both set forces the one-cycle clear
    always_comb begin
        state_nx = state;
        unique case (state)
            PFD_IDLE: begin
                if (ref_rise && fb_rise) state_nx = PFD_BOTH;
                else if (ref_rise)       state_nx = PFD_UP;
                else if (fb_rise)        state_nx = PFD_DN;
            end
            PFD_UP: begin
                if (fb_rise) state_nx = PFD_BOTH;
            end
            PFD_DN: begin
                if (ref_rise) state_nx = PFD_BOTH;
            end
            PFD_BOTH: begin
                if (ref_rise && fb_rise) state_nx = PFD_BOTH;
                else if (ref_rise)       state_nx = PFD_UP;
                else if (fb_rise)        state_nx = PFD_DN;
                else                     state_nx = PFD_IDLE;
            end
            default: state_nx = PFD_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        up = 1'b0;
        dn = 1'b0;
        unique case (state)
            PFD_IDLE: ;
            PFD_UP:   up = 1'b1;
            PFD_DN:   dn = 1'b1;
            PFD_BOTH: begin
                up = 1'b1;
                dn = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pfd_lock_qual.sv
module pfd_lock_qual
    import pfd_pkg::*;
#(
    parameter int LIMIT_W     = 8,
    parameter int LOCK_CYCLES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               up,
    input  logic               dn,
    input  logic [LIMIT_W-1:0] lock_limit,
    output logic               lock
);
    localparam int RUN_W = LIMIT_W + 1;
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam int unsigned RUN_MAX = (1 << RUN_W) - 1;

    logic [RUN_W-1:0] run;       // cycles spent with exactly one output high
    logic [RUN_W-1:0] width_now; // width of the current pulse so far
    logic [CNT_W-1:0] good;      // consecutive qualifying comparisons
    logic             active, clear_cyc, wide;

    assign active    = up | dn;
    assign clear_cyc = up & dn;
    assign width_now = RUN_W'(sat_inc(int'(run), RUN_MAX));
    assign wide      = active && (width_now > {1'b0, lock_limit});

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= '0;
        end else if (up ^ dn) begin
            run <= RUN_W'(sat_inc(int'(run), RUN_MAX));
        end else begin
            run <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            good <= '0;
            lock <= 1'b0;
        end else if (wide) begin
            good <= '0;
            lock <= 1'b0;
        end else if (clear_cyc) begin
            good <= CNT_W'(sat_inc(int'(good), LOCK_CYCLES));
            if (int'(good) >= LOCK_CYCLES - 1) lock <= 1'b1;
        end
    end
endmodule

// File: rtl/pfd_detector.sv
module pfd_detector #(
    parameter int SYNC_STAGES = 2,
    parameter int LIMIT_W     = 8,
    parameter int LOCK_CYCLES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_in,
    input  logic               fb_in,
    input  logic [LIMIT_W-1:0] lock_limit,
    output logic               up,
    output logic               dn,
    output logic               lock
);
    logic ref_rise, fb_rise;

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_edge (
        .clk(clk), .rst(rst), .din(ref_in), .rise(ref_rise)
    );

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_edge (
        .clk(clk), .rst(rst), .din(fb_in), .rise(fb_rise)
    );

    pfd_fsm u_fsm (
        .clk(clk), .rst(rst), .ref_rise(ref_rise), .fb_rise(fb_rise),
        .up(up), .dn(dn)
    );

    pfd_lock_qual #(.LIMIT_W(LIMIT_W), .LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk(clk), .rst(rst), .up(up), .dn(dn),
        .lock_limit(lock_limit), .lock(lock)
    );
endmodule

// File: rtl/pfd_detector_checker.sv
module pfd_detector_checker (
    input logic clk,
    input logic rst,
    input logic up,
    input logic dn,
    input logic lock
);
    // R1: reset empties every output one cycle later
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!up && !dn && !lock));

    // R2: a lone up pulse is held until the clear cycle
    assert_up_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (up && !dn) |=> up);

    // R3: a lone down pulse is held until the clear cycle
    assert_dn_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (dn && !up) |=> dn);

    // R4: the both-high clear never lasts two cycles
    assert_clear_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        (up && dn) |=> !(up && dn));

    // R8: lock only rises right after a completed comparison
    assert_lock_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $past(up && dn));

    // R9: outside reset, lock only falls during a pulse
    assert_lock_fall_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(lock) && !$past(rst)) |-> $past(up || dn));
endmodule

bind pfd_detector pfd_detector_checker i_pfd_detector_checker (
    .clk(clk), .rst(rst), .up(up), .dn(dn), .lock(lock)
);

// File: tb/test_pfd_detector.sv
module test_pfd_detector;
    localparam int LIMIT_W = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               ref_in = 1'b0;
    logic               fb_in = 1'b0;
    logic [LIMIT_W-1:0] lock_limit = 8'd2;
    logic               up, dn, lock;

    int errors = 0;
    int checks = 0;
    int up_cnt = 0;
    int dn_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    pfd_detector #(.SYNC_STAGES(2), .LIMIT_W(LIMIT_W), .LOCK_CYCLES(8)) i_pfd_detector (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .lock_limit(lock_limit), .up(up), .dn(dn), .lock(lock)
    );

    // Count high cycles of each output, sampled away from the active edge
    always @(negedge clk) begin
        if (up) up_cnt++;
        if (dn) dn_cnt++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        @(posedge clk);
        up_cnt = 0;
        dn_cnt = 0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ref_in = 1'b0;
        fb_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // One comparison: the leading input rises, the other follows gap cycles later
    task automatic pair(input bit ref_first, input int gap);
        clear_counts();
        if (gap == 0) begin
            ref_in = 1'b1;
            fb_in = 1'b1;
        end else begin
            if (ref_first) ref_in = 1'b1; else fb_in = 1'b1;
            repeat (gap) @(negedge clk);
            if (ref_first) fb_in = 1'b1; else ref_in = 1'b1;
        end
        repeat (3) @(negedge clk);
        ref_in = 1'b0;
        fb_in = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic test_reset_state();
        check("R1 up after reset", int'(up), 0);
        check("R1 dn after reset", int'(dn), 0);
        check("R1 lock after reset", int'(lock), 0);
    endtask

    task automatic test_ref_leads();
        pair(1'b1, 3);
        check("R5 up width ref leads 3", up_cnt, 4);
        check("R5 dn width ref leads 3", dn_cnt, 1);
        check("R2 up low after clear", int'(up), 0);
    endtask

    task automatic test_fb_leads();
        pair(1'b0, 5);
        check("R5 dn width fb leads 5", dn_cnt, 6);
        check("R5 up width fb leads 5", up_cnt, 1);
        check("R3 dn low after clear", int'(dn), 0);
    endtask

    task automatic test_zero_phase();
        pair(1'b1, 0);
        check("R6 up minimum pulse", up_cnt, 1);
        check("R6 dn minimum pulse", dn_cnt, 1);
    endtask

    // Second reference edge while up is set must not restart the pulse
    task automatic test_repeat_ref();
        clear_counts();
        ref_in = 1'b1;
        repeat (2) @(negedge clk);
        ref_in = 1'b0;
        repeat (2) @(negedge clk);
        ref_in = 1'b1;
        repeat (2) @(negedge clk);
        fb_in = 1'b1;
        repeat (3) @(negedge clk);
        ref_in = 1'b0;
        fb_in = 1'b0;
        repeat (6) @(negedge clk);
        check("R2 repeated ref edge ignored, up width", up_cnt, 7);
        check("R2 repeated ref edge, dn width", dn_cnt, 1);
    endtask

    task automatic test_repeat_fb();
        clear_counts();
        fb_in = 1'b1;
        repeat (2) @(negedge clk);
        fb_in = 1'b0;
        repeat (2) @(negedge clk);
        fb_in = 1'b1;
        repeat (1) @(negedge clk);
        ref_in = 1'b1;
        repeat (3) @(negedge clk);
        ref_in = 1'b0;
        fb_in = 1'b0;
        repeat (6) @(negedge clk);
        check("R3 repeated fb edge ignored, dn width", dn_cnt, 6);
    endtask

    task automatic run_freq(input int ref_per, input int fb_per);
        clear_counts();
        for (int t = 0; t < 108; t++) begin
            ref_in = (t % ref_per) < (ref_per / 2);
            fb_in  = (t % fb_per) < (fb_per / 2);
            @(negedge clk);
        end
        ref_in = 1'b0;
        fb_in = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic test_freq();
        run_freq(6, 9);
        check("R7 fast reference up dominated", int'(up_cnt > dn_cnt), 1);
        run_freq(9, 6);
        check("R7 slow reference dn dominated", int'(dn_cnt > up_cnt), 1);
    endtask

    task automatic test_lock();
        do_reset();
        for (int i = 0; i < 7; i++) pair(1'b1, 1);
        check("R8 no lock after 7 good comparisons", int'(lock), 0);
        pair(1'b1, 1);
        check("R8 lock after 8th good comparison", int'(lock), 1);
    endtask

    task automatic test_unlock();
        clear_counts();
        ref_in = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 lock dropped during wide pulse", int'(lock), 0);
        check("R9 up still high during wide pulse", int'(up), 1);
        fb_in = 1'b1;
        repeat (3) @(negedge clk);
        ref_in = 1'b0;
        fb_in = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 7; i++) pair(1'b0, 0);
        check("R9 count restarted, 7 good not enough", int'(lock), 0);
        pair(1'b0, 1);
        check("R9 relock on 8th good comparison", int'(lock), 1);
    endtask

    task automatic test_reset_mid_pulse();
        ref_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 up high before reset", int'(up), 1);
        rst = 1'b1;
        ref_in = 1'b0;
        @(negedge clk);
        check("R1 up cleared by reset", int'(up), 0);
        check("R1 lock cleared by reset", int'(lock), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 outputs stay idle after reset", int'(up | dn | lock), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset_state();
        test_ref_leads();
        test_fb_leads();
        test_zero_phase();
        test_repeat_ref();
        test_repeat_fb();
        test_freq();
        test_lock();
        test_unlock();
        test_reset_mid_pulse();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule